// File: doc/BRIEF.md
# Phase-Shared Video Memory with Latched CPU Writes

This block puts one video memory behind a two-slot schedule. The display side and a CPU write latch share that memory by taking turns. In a read slot, the display address is looked up and the byte lands in a registered output. In the next slot, a write slot, the latch commits its address/data pair to memory, but only if the latch holds a pending write. The block is clocked at twice the rate of the display memory cycle, so each pair of clock cycles stands for the high and low halves of one memory cycle.

The CPU reaches the latch through a small I/O port with two registers: a data register and a control register. The CPU never waits. Each data write either completes a byte or contributes half of one. Software picks one of two loading widths. In byte mode, one write delivers a full byte. In nibble mode, two writes deliver the low half first and then the high half. A status output shows that a write is waiting. A sticky overrun flag records that a waiting write was overwritten before it could be committed.

The default address width gives a 2 KiB store. With `ADDR_W = 15` and `DATA_W = 8`, the block holds a 32 KiB frame of 320x200 pixels at 4 bits per pixel.

Top module: `vidmem_phase_port`

## Requirements
- R1: While reset is low, and at the first falling edge after reset, `wr_pending`, `overrun`, `nibble_mode` and `nib_waiting` are 0, `read_phase` is 1 and `vid_rdata` is 0.
- R2: `read_phase` is 1 after reset and inverts on every rising clock edge. An edge taken while it is 1 is a read slot. An edge taken while it is 0 is a write slot.
- R3: At a read-slot edge, `vid_rdata` takes the memory byte at `vid_addr`. At a write-slot edge, `vid_rdata` keeps its value.
- R4: The memory is written only at a write-slot edge where `wr_pending` was 1. With nothing pending, the memory is untouched.
- R5: `wr_pending` goes to 1 at the edge where a data write completes a byte. It returns to 0 at the write-slot edge that commits the byte, unless a new byte completes on that same edge.
- R6: In byte mode (`nibble_mode` = 0), a data-register write (`io_wr`=1, `io_reg`=0) latches `io_addr` and all of `io_wdata` as one pending write.
- R7: In nibble mode, the first data write stores `io_wdata[3:0]` as the low nibble and raises `nib_waiting` without touching `wr_pending`. The second data write supplies `io_wdata[3:0]` as the high nibble and supplies the address. The upper bits of `io_wdata` are ignored in this mode.
- R8: A control-register write (`io_wr`=1, `io_reg`=1) sets `nibble_mode` from `io_wdata[0]` and discards any half-assembled nibble, clearing `nib_waiting`.
- R9: If a byte completes while a write is pending and the same edge does not commit it, the latch takes the new pair and `overrun` goes to 1 and stays there.
- R10: A control write with `io_wdata[1]` = 1 clears `overrun`.
- R11: If a byte completes on the write-slot edge that commits the previous one, the old pair is written, the new pair becomes pending, and `overrun` is not set.
- R12: A committed write always uses the address and data that were latched together on the same CPU write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; two cycles form one memory cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | CPU port write strobe, one cycle per access |
| io_reg | input | 1 | Register select: 0 data, 1 control |
| io_addr | input | ADDR_W | Video memory address for a data write |
| io_wdata | input | DATA_W | Write data; control bit 0 is nibble mode, bit 1 clears overrun |
| vid_addr | input | ADDR_W | Display read address |
| vid_rdata | output | DATA_W | Byte read in the last read slot |
| read_phase | output | 1 | 1 when the next edge is a read slot |
| wr_pending | output | 1 | The latch holds an uncommitted write |
| overrun | output | 1 | Sticky: a pending write was overwritten |
| nibble_mode | output | 1 | Current loading width: 1 nibble, 0 byte |
| nib_waiting | output | 1 | A low nibble is held, waiting for its high half |

## Verification
The bench builds the block with `ADDR_W = 6`, `DATA_W = 8` and nibble support on. With a 64-byte store, the bench can fill every location and read the whole store back through the display port in a few hundred cycles. That makes each commit visible at the output. The nibble variant brings mode switching, abandoned half-bytes and the ignored upper data bits within reach. Writes driven on consecutive cycles, landing on both slot parities, exercise overrun and the write that arrives on its own commit edge.

// File: rtl/vmp_pkg.sv
package vmp_pkg;

   typedef enum logic {
      SLOT_READ  = 1'b0,
      SLOT_WRITE = 1'b1
   } slot_e;

   localparam logic IOREG_DATA = 1'b0;
   localparam logic IOREG_CTRL = 1'b1;

   localparam int CTRL_BIT_NIBBLE  = 0;
   localparam int CTRL_BIT_CLR_OVR = 1;

endpackage

// File: rtl/vmp_slot_ctl.sv
module vmp_slot_ctl
   import vmp_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pending,
   output slot_e slot,
   output logic  rd_en,
   output logic  wr_en
);

   slot_e slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= SLOT_READ;
      end else begin
         slot_q <= (slot_q == SLOT_READ) ? SLOT_WRITE : SLOT_READ;
      end
   end

   assign slot  = slot_q;
   assign rd_en = (slot_q == SLOT_READ);
   assign wr_en = (slot_q == SLOT_WRITE) && pending;

endmodule

// File: rtl/vmp_wr_latch.sv
module vmp_wr_latch
   import vmp_pkg::*;
#(
   parameter int ADDR_W     = 11,
   parameter int DATA_W     = 8,
   parameter bit HAS_NIBBLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic              io_reg,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              commit,
   output logic              pending,
   output logic              overrun,
   output logic              nib_mode,
   output logic              nib_half,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [DATA_W-1:0] lat_data
);

   localparam int NIB_W = DATA_W / 2;

   logic              data_wr;
   logic              ctrl_wr;
   logic              complete;
   logic [DATA_W-1:0] word;

   assign data_wr = io_wr && (io_reg == IOREG_DATA);
   assign ctrl_wr = io_wr && (io_reg == IOREG_CTRL);

   generate
      if (HAS_NIBBLE) begin : g_nibble
         logic             mode_q;
         logic             half_q;
         logic [NIB_W-1:0] lo_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mode_q <= 1'b0;
               half_q <= 1'b0;
               lo_q   <= '0;
            end else if (ctrl_wr) begin
               mode_q <= io_wdata[CTRL_BIT_NIBBLE];
               half_q <= 1'b0;
            end else if (data_wr && mode_q) begin
               if (!half_q) begin
                  lo_q   <= io_wdata[NIB_W-1:0];
                  half_q <= 1'b1;
               end else begin
                  half_q <= 1'b0;
               end
            end
         end

         assign complete = data_wr && (!mode_q || half_q);
         assign word     = mode_q ? {io_wdata[NIB_W-1:0], lo_q} : io_wdata;
         assign nib_mode = mode_q;
         assign nib_half = half_q;
      end else begin : g_byte_only
         assign complete = data_wr;
         assign word     = io_wdata;
         assign nib_mode = 1'b0;
         assign nib_half = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending  <= 1'b0;
         overrun  <= 1'b0;
         lat_addr <= '0;
         lat_data <= '0;
      end else begin
         if (complete) begin
            lat_addr <= io_addr;
            lat_data <= word;
            pending  <= 1'b1;
            if (pending && !commit) begin
               overrun <= 1'b1;
            end
         end else if (commit) begin
            pending <= 1'b0;
         end
         if (ctrl_wr && io_wdata[CTRL_BIT_CLR_OVR]) begin
            overrun <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/vmp_frame_ram.sv
module vmp_frame_ram #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              we,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         store[wr_addr] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= store[rd_addr];
      end
   end

endmodule

// File: rtl/vidmem_phase_port.sv
module vidmem_phase_port
   import vmp_pkg::*;
#(
   parameter int ADDR_W     = 11,
   parameter int DATA_W     = 8,
   parameter bit HAS_NIBBLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic              io_reg,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic [ADDR_W-1:0] vid_addr,
   output logic [DATA_W-1:0] vid_rdata,
   output logic              read_phase,
   output logic              wr_pending,
   output logic              overrun,
   output logic              nibble_mode,
   output logic              nib_waiting
);

   generate
      if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr_w
         $error("vidmem_phase_port: ADDR_W out of range");
      end
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_data_w
         $error("vidmem_phase_port: DATA_W must be even and at least 2");
      end
   endgenerate

   slot_e             slot;
   logic              ram_rd;
   logic              ram_we;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_data;

   vmp_slot_ctl u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .pending (wr_pending),
      .slot    (slot),
      .rd_en   (ram_rd),
      .wr_en   (ram_we)
   );

   vmp_wr_latch #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .HAS_NIBBLE (HAS_NIBBLE)
   ) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_wr    (io_wr),
      .io_reg   (io_reg),
      .io_addr  (io_addr),
      .io_wdata (io_wdata),
      .commit   (ram_we),
      .pending  (wr_pending),
      .overrun  (overrun),
      .nib_mode (nibble_mode),
      .nib_half (nib_waiting),
      .lat_addr (lat_addr),
      .lat_data (lat_data)
   );

   vmp_frame_ram #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (ram_rd),
      .rd_addr (vid_addr),
      .rd_data (vid_rdata),
      .we      (ram_we),
      .wr_addr (lat_addr),
      .wr_data (lat_data)
   );

   assign read_phase = (slot == SLOT_READ);

endmodule

// File: rtl/vmp_port_chk.sv
module vmp_port_chk #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_wr,
   input logic              io_reg,
   input logic [DATA_W-1:0] io_wdata,
   input logic [DATA_W-1:0] vid_rdata,
   input logic              read_phase,
   input logic              wr_pending,
   input logic              overrun,
   input logic              nibble_mode,
   input logic              nib_waiting,
   input logic              ram_we
);

   assert_slot_rd_to_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      read_phase |=> !read_phase);

   assert_slot_wr_to_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !read_phase |=> read_phase);

   assert_hold_in_write_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !read_phase |=> $stable(vid_rdata));

   assert_write_only_when_owed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (!read_phase && wr_pending));

   assert_pending_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!read_phase && wr_pending && !io_wr) |=> !wr_pending);

   assert_byte_sets_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_reg && !nibble_mode) |=> wr_pending);

   assert_first_nibble_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_reg && nibble_mode && !nib_waiting && !wr_pending)
      |=> (nib_waiting && !wr_pending));

   assert_ctrl_drops_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_reg) |=> !nib_waiting);

   assert_overrun_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_reg && wr_pending && read_phase && (!nibble_mode || nib_waiting))
      |=> overrun);

   assert_overrun_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_reg && io_wdata[1]) |=> !overrun);

   assert_no_overrun_on_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_reg && !nibble_mode && !read_phase && wr_pending && !overrun)
      |=> (wr_pending && !overrun));

endmodule

bind vidmem_phase_port vmp_port_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_port_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_wr       (io_wr),
   .io_reg      (io_reg),
   .io_wdata    (io_wdata),
   .vid_rdata   (vid_rdata),
   .read_phase  (read_phase),
   .wr_pending  (wr_pending),
   .overrun     (overrun),
   .nibble_mode (nibble_mode),
   .nib_waiting (nib_waiting),
   .ram_we      (ram_we)
);

// File: tb/vidmem_phase_port_bench.sv
module vidmem_phase_port_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 6;
   localparam int DW         = 8;
   localparam int DEPTH      = 1 << AW;
   localparam int WATCHDOG   = 50000;

   logic          clk      = 1'b0;
   logic          rst_n    = 1'b0;
   logic          io_wr    = 1'b0;
   logic          io_reg   = 1'b0;
   logic [AW-1:0] io_addr  = '0;
   logic [DW-1:0] io_wdata = '0;
   logic [AW-1:0] vid_addr = '0;
   logic [DW-1:0] vid_rdata;
   logic          read_phase;
   logic          wr_pending;
   logic          overrun;
   logic          nibble_mode;
   logic          nib_waiting;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vidmem_phase_port #(
      .ADDR_W     (AW),
      .DATA_W     (DW),
      .HAS_NIBBLE (1'b1)
   ) u_vidmem_phase_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .io_wr       (io_wr),
      .io_reg      (io_reg),
      .io_addr     (io_addr),
      .io_wdata    (io_wdata),
      .vid_addr    (vid_addr),
      .vid_rdata   (vid_rdata),
      .read_phase  (read_phase),
      .wr_pending  (wr_pending),
      .overrun     (overrun),
      .nibble_mode (nibble_mode),
      .nib_waiting (nib_waiting)
   );

   // Behavioural reference model: -1 marks a location never written
   int m_mem [DEPTH];
   int m_rd, m_pend, m_ovr, m_mode, m_half, m_lo, m_addr, m_data, m_rdata;

   initial begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = -1;
      m_rd = 1; m_pend = 0; m_ovr = 0; m_mode = 0; m_half = 0;
      m_lo = 0; m_addr = 0; m_data = 0; m_rdata = 0;
   end

   always @(posedge clk) begin : ref_model
      int commit;
      int complete;
      int word;
      if (!rst_n) begin
         m_rd = 1; m_pend = 0; m_ovr = 0; m_mode = 0; m_half = 0;
         m_lo = 0; m_addr = 0; m_data = 0; m_rdata = 0;
      end else begin
         commit   = (m_rd == 0 && m_pend == 1) ? 1 : 0;
         complete = 0;
         word     = 0;
         if (m_rd == 1) m_rdata = m_mem[int'(vid_addr)];
         if (commit == 1) m_mem[m_addr] = m_data;
         if (io_wr && io_reg == 1'b0) begin
            if (m_mode == 0) begin
               complete = 1;
               word     = int'(io_wdata);
            end else if (m_half == 0) begin
               m_lo   = int'(io_wdata) % 16;
               m_half = 1;
            end else begin
               complete = 1;
               word     = (int'(io_wdata) % 16) * 16 + m_lo;
               m_half   = 0;
            end
         end
         if (io_wr && io_reg == 1'b1) begin
            m_mode = io_wdata[0] ? 1 : 0;
            m_half = 0;
            if (io_wdata[1]) m_ovr = 0;
         end
         if (complete == 1) begin
            if (m_pend == 1 && commit == 0) m_ovr = 1;
            m_pend = 1;
            m_addr = int'(io_addr);
            m_data = word;
         end else if (commit == 1) begin
            m_pend = 0;
         end
         m_rd = 1 - m_rd;
      end
   end

   task automatic cmp(input int act, input int exp, input string tag);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cmp(int'(read_phase),  m_rd,   "R2 slot order");
         cmp(int'(wr_pending),  m_pend, "R5 pending flag");
         cmp(int'(overrun),     m_ovr,  "R9 overrun flag");
         cmp(int'(nibble_mode), m_mode, "R8 load mode");
         cmp(int'(nib_waiting), m_half, "R7 nibble assembly");
         if (m_rdata >= 0) cmp(int'(vid_rdata), m_rdata, "R3 display read");
      end
   end

   task automatic data_wr(input int a, input int d);
      @(negedge clk);
      io_wr = 1'b1; io_reg = 1'b0;
      io_addr = AW'(a); io_wdata = DW'(d);
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic ctrl_wr(input int d);
      @(negedge clk);
      io_wr = 1'b1; io_reg = 1'b1; io_wdata = DW'(d);
      @(negedge clk);
      io_wr = 1'b0; io_reg = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd_expect(input int a, input int exp, input string tag);
      @(negedge clk);
      vid_addr = AW'(a);
      repeat (2) @(posedge clk);
      @(negedge clk);
      cmp(int'(vid_rdata), exp, tag);
   endtask

   function automatic int fill_val(input int a);
      return (a * 7 + 3) % 256;
   endfunction

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
         finish_run();
      end
   end

   initial begin : stimulus
      // R1: reset state
      repeat (3) @(negedge clk);
      cmp(int'(wr_pending),  0, "R1 reset pending");
      cmp(int'(overrun),     0, "R1 reset overrun");
      cmp(int'(nibble_mode), 0, "R1 reset mode");
      cmp(int'(nib_waiting), 0, "R1 reset nibble");
      cmp(int'(read_phase),  1, "R1 reset slot");
      cmp(int'(vid_rdata),   0, "R1 reset read data");
      rst_n = 1'b1;

      // R6: byte-mode fill of the whole store
      for (int a = 0; a < DEPTH; a++) begin
         data_wr(a, fill_val(a));
         idle(1);
      end
      idle(4);
      cmp(int'(overrun), 0, "R9 no overrun on paced writes");

      // R12 / R6: directed readback
      rd_expect(0,  fill_val(0),  "R6 readback addr 0");
      rd_expect(37, fill_val(37), "R12 readback addr 37");
      rd_expect(63, fill_val(63), "R12 readback addr 63");

      // R3: sweep display address every cycle
      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk);
         vid_addr = AW'(DEPTH - 1 - a);
      end
      idle(2);

      // R9: back-to-back writes on every cycle
      @(negedge clk);
      for (int k = 0; k < 6; k++) begin
         io_wr = 1'b1; io_reg = 1'b0;
         io_addr = AW'(20 + k); io_wdata = DW'(8'h40 + k);
         @(negedge clk);
      end
      io_wr = 1'b0;
      idle(4);
      cmp(int'(overrun), 1, "R9 overrun after burst");

      // R10: clear overrun, keep byte mode
      ctrl_wr(2);
      cmp(int'(overrun), 0, "R10 overrun cleared");
      cmp(int'(nibble_mode), 0, "R10 mode kept");

      // R11: a write on its predecessor's commit edge
      while (read_phase != 1'b1) @(negedge clk);
      io_wr = 1'b1; io_reg = 1'b0; io_addr = AW'(30); io_wdata = 8'hA1;
      @(negedge clk);
      io_addr = AW'(31); io_wdata = 8'hB2;
      @(negedge clk);
      io_wr = 1'b0;
      cmp(int'(wr_pending), 1, "R11 second pair pending");
      cmp(int'(overrun),    0, "R11 no overrun");
      idle(4);
      rd_expect(30, 8'hA1, "R11 first pair written");
      rd_expect(31, 8'hB2, "R11 second pair written");

      // R7: nibble loading, upper bits ignored
      ctrl_wr(1);
      cmp(int'(nibble_mode), 1, "R8 nibble mode on");
      data_wr(10, 8'hF5);
      cmp(int'(nib_waiting), 1, "R7 low nibble held");
      cmp(int'(wr_pending),  0, "R7 no pending after one nibble");
      data_wr(10, 8'hA9);
      cmp(int'(nib_waiting), 0, "R7 assembly done");
      idle(4);
      rd_expect(10, 8'h95, "R7 assembled byte");

      // R8: control write discards half-built byte
      data_wr(11, 8'h03);
      ctrl_wr(1);
      cmp(int'(nib_waiting), 0, "R8 half discarded");
      data_wr(11, 8'h04);
      data_wr(11, 8'h02);
      idle(4);
      rd_expect(11, 8'h24, "R8 fresh assembly");

      // back to byte mode
      ctrl_wr(0);
      cmp(int'(nibble_mode), 0, "R8 byte mode restored");
      data_wr(12, 8'hC3);
      idle(4);
      rd_expect(12, 8'hC3, "R6 byte after mode switch");

      // R4: idle period leaves memory unchanged
      idle(40);
      rd_expect(12, 8'hC3, "R4 store unchanged addr 12");
      rd_expect(1,  fill_val(1), "R4 store unchanged addr 1");
      rd_expect(25, 8'h45, "R4 store unchanged addr 25");

      idle(2);
      finish_run();
   end

endmodule